// File: doc/BRIEF.md
# Multi-Count Shift and Rotate Unit

This combinational datapath block moves bits in an 8-, 16- or 32-bit operand. It covers arithmetic and logical shifts, plain rotates, and rotates through the extend flag. It also does sign extension and swapping the two halves of a register. Every shift or rotate over any count finishes in one evaluation.

The count comes from one of two places. A 3-bit immediate field encodes 1 to 8. The low six bits of a data register give 0 to 63. A memory-operand flag overrides both count and size, so the operation becomes a one-bit move of a 16-bit word.

The result keeps the operand's bits above the selected size. Five condition flags come out alongside it: extend (X), negative (N), zero (Z), overflow (V) and carry (C). Register access and instruction decode sit outside the block.

Top module: `shrot_unit`

## Requirements
- R1: With `cnt_src_i` = 0 the count is `imm_cnt_i`, where code 0 means 8 and codes 1 to 7 mean themselves.
- R2: With `cnt_src_i` = 1 the count is `reg_cnt_i` (0 to 63, the register value modulo 64).
- R3: With `mem_i` = 1 the operation is a one-bit move at word size, whatever `size_i`, `cnt_src_i` and the count inputs hold.
- R4: The logical shifts (LSL = 2, LSR = 3) and the arithmetic right shift (ASR = 1) give the same result as n single-bit steps. ASR fills with the sign bit. C is the last bit shifted out, and X takes C when n > 0.
- R5: The arithmetic left shift (ASL = 0) shifts like LSL. It sets V when the operand's sign bit takes more than one value at any point during the n steps.
- R6: The plain rotates (ROL = 4, ROR = 5) circulate 8, 16 or 32 bits. C is the last bit rotated out and X is left unchanged.
- R7: The extend rotates (ROXL = 6, ROXR = 7) circulate 9, 17 or 33 bits, with X as the extra bit. C and X both take the final extra bit.
- R8: A zero count leaves the result unchanged and gives V = 0 and an unchanged X. C = 0, except for extend rotates, where C = X.
- R9: EXT (8) with size 0 sign-extends bits 7:0 into bits 15:0 and keeps bits 31:16. Size 1 sign-extends bits 15:0 to 32 bits. Size 2 sign-extends bits 7:0 to 32 bits.
- R10: SWAP (9) exchanges bits 31:16 and 15:0. C = V = 0 and X is unchanged.
- R11: N is the top bit and Z flags an all-zero value, both taken at the operand size. For EXT the size is the destination size (word for size 0, long otherwise), and for SWAP it is long. V = 0 for every operation except ASL. Size codes: 0 byte, 1 word, 2 long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand value |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| op_i | input | 4 | Operation code 0 to 9 |
| cnt_src_i | input | 1 | Count source: 0 immediate, 1 register |
| imm_cnt_i | input | 3 | Immediate count code (0 means 8) |
| reg_cnt_i | input | 6 | Low six bits of the count register |
| mem_i | input | 1 | Memory operand: one-bit word move |
| x_i | input | 1 | Incoming extend flag |
| result_o | output | 32 | Result, upper bits kept from the operand |
| x_o | output | 1 | Extend flag out |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The block is combinational, so a fault in the internal state shows at the ports on the same set of input values. Typical faults are a wrongly resolved count, a rotation amount reduced by the wrong modulus, or the extend bit misplaced in the rotation vector. Each appears as a corrupted result or as C and X disagreeing with the last bit moved.

Size-dependent faults, such as a bad mask or sign position, only show when the operand has bits set near the size boundary. The random operands therefore vary all three sizes and counts past the operand width. Extend-rotate modulus errors only show for counts above the operand width, so 9-, 17- and 33-bit cycles are driven directly.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_L = 2'd2
    } size_e;

    typedef enum logic [3:0] {
        OP_ASL  = 4'd0,
        OP_ASR  = 4'd1,
        OP_LSL  = 4'd2,
        OP_LSR  = 4'd3,
        OP_ROL  = 4'd4,
        OP_ROR  = 4'd5,
        OP_ROXL = 4'd6,
        OP_ROXR = 4'd7,
        OP_EXT  = 4'd8,
        OP_SWAP = 4'd9
    } op_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;
    localparam int IMM_W  = 3;

    function automatic logic [CNT_W-1:0] sz_bits(size_e s);
        case (s)
            SZ_B:    return 6'd8;
            SZ_W:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] sz_mask(size_e s);
        case (s)
            SZ_B:    return 32'h0000_00FF;
            SZ_W:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic sz_msb(logic [DATA_W-1:0] v, size_e s);
        case (s)
            SZ_B:    return v[7];
            SZ_W:    return v[15];
            default: return v[31];
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] sz_sext(logic [DATA_W-1:0] v, size_e s);
        case (s)
            SZ_B:    return {{24{v[7]}}, v[7:0]};
            SZ_W:    return {{16{v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/shrot_cnt.sv
module shrot_cnt
    import shrot_pkg::*;
(
    input  logic             src_reg,
    input  logic [IMM_W-1:0] imm_code,
    input  logic [CNT_W-1:0] reg_val,
    input  logic             mem_op,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] IMM_ZERO_CNT = CNT_W'(1 << IMM_W);

    always_comb begin
        if (mem_op)
            cnt = 6'd1;
        else if (!src_reg)
            cnt = (imm_code == '0) ? IMM_ZERO_CNT : CNT_W'(imm_code);
        else
            cnt = reg_val;
        // R1
        imm_range_chk: assert (mem_op || src_reg || (cnt >= 6'd1 && cnt <= IMM_ZERO_CNT))
            else $error("immediate count out of range");
    end
endmodule

// File: rtl/shrot_shift.sv
module shrot_shift
    import shrot_pkg::*;
(
    input  op_e               op,
    input  size_e             size,
    input  logic [DATA_W-1:0] a,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              x_in,
    output logic [DATA_W-1:0] res,
    output logic              c,
    output logic              v,
    output logic              x_out
);
    logic [CNT_W-1:0]    w;
    logic [DATA_W-1:0]   msk, aw, sx, r, top, ones;
    logic [2*DATA_W-1:0] lv;
    logic [3*DATA_W-1:0] rv, arv;
    logic                cl, cr, ca;

    always_comb begin
        w   = sz_bits(size);
        msk = sz_mask(size);
        aw  = a & msk;
        sx  = sz_sext(a, size);
        lv  = {{DATA_W{1'b0}}, aw} << cnt;
        rv  = {aw, {2*DATA_W{1'b0}}} >> cnt;
        arv = $signed({sx, {2*DATA_W{1'b0}}}) >>> cnt;
        cl  = lv[w];
        cr  = rv[2*DATA_W-1];
        ca  = arv[2*DATA_W-1];

        // overflow window for ASL: bits w-1 down to w-1-n must all agree
        top  = '0;
        ones = '0;
        v    = 1'b0;
        if (op == OP_ASL && cnt != '0) begin
            if (cnt >= w) begin
                v = (aw != '0);
            end else begin
                top  = aw >> (w - 6'd1 - cnt);
                ones = DATA_W'((64'd1 << (cnt + 6'd1)) - 64'd1);
                v    = (top != '0) && (top != ones);
            end
        end

        case (op)
            OP_LSR:  begin r = rv[3*DATA_W-1:2*DATA_W];  c = cr; end
            OP_ASR:  begin r = arv[3*DATA_W-1:2*DATA_W]; c = ca; end
            default: begin r = lv[DATA_W-1:0];           c = cl; end
        endcase
        if (cnt == '0) c = 1'b0;
        res   = (a & ~msk) | (r & msk);
        x_out = (cnt == '0) ? x_in : c;

        // R8
        zero_cnt_keep_chk: assert (cnt != '0 || (res == a && !c && !v && x_out == x_in))
            else $error("zero count altered shift state");
        // R4
        upper_kept_chk: assert (((res ^ a) & ~msk) == '0)
            else $error("shift touched bits above size");
    end
endmodule

// File: rtl/shrot_rot.sv
module shrot_rot
    import shrot_pkg::*;
(
    input  op_e               op,
    input  size_e             size,
    input  logic [DATA_W-1:0] a,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              x_in,
    output logic [DATA_W-1:0] res,
    output logic              c,
    output logic              x_out
);
    logic [CNT_W-1:0]    w, we, mp, me, pl, el;
    logic [DATA_W-1:0]   msk, aw, rp, re, r;
    logic [2*DATA_W-1:0] e64, t, ev, t2, emsk;
    logic                nx;

    always_comb begin
        w    = sz_bits(size);
        we   = w + 6'd1;
        msk  = sz_mask(size);
        aw   = a & msk;
        mp   = cnt % w;
        me   = cnt % we;

        // plain rotate: everything expressed as a left rotation
        pl   = (op == OP_ROL || mp == '0) ? mp : (w - mp);
        e64  = {{DATA_W{1'b0}}, aw};
        t    = (e64 << pl) | (e64 >> (w - pl));
        rp   = t[DATA_W-1:0] & msk;

        // extend rotate: X sits just above the operand's top bit
        el   = (op == OP_ROXL || me == '0) ? me : (we - me);
        ev   = e64 | ({{(2*DATA_W-1){1'b0}}, x_in} << w);
        emsk = (64'd1 << we) - 64'd1;
        t2   = ((ev << el) | (ev >> (we - el))) & emsk;
        re   = t2[DATA_W-1:0] & msk;
        nx   = t2[w];

        case (op)
            OP_ROL:  begin r = rp; c = (cnt == '0) ? 1'b0 : rp[0];            x_out = x_in; end
            OP_ROR:  begin r = rp; c = (cnt == '0) ? 1'b0 : sz_msb(rp, size); x_out = x_in; end
            default: begin r = re; c = nx;                                    x_out = nx;   end
        endcase
        res = (a & ~msk) | r;

        // R6
        rot_bits_kept_chk: assert (!(op == OP_ROL || op == OP_ROR) || $countones(rp) == $countones(aw))
            else $error("plain rotate lost bits");
        // R7
        rox_bits_kept_chk: assert (!(op == OP_ROXL || op == OP_ROXR)
                                   || ($countones(re) + 32'(nx)) == ($countones(aw) + 32'(x_in)))
            else $error("extend rotate lost bits");
    end
endmodule

// File: rtl/shrot_xsw.sv
module shrot_xsw
    import shrot_pkg::*;
(
    input  op_e               op,
    input  size_e             size,
    input  logic [DATA_W-1:0] a,
    output logic [DATA_W-1:0] res,
    output size_e             fsz
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        if (op == OP_SWAP) begin
            res = {a[HALF-1:0], a[DATA_W-1:HALF]};
            fsz = SZ_L;
        end else begin
            case (size)
                SZ_B: begin
                    res = {a[DATA_W-1:HALF], {(HALF-8){a[7]}}, a[7:0]};
                    fsz = SZ_W;
                end
                SZ_W: begin
                    res = {{HALF{a[HALF-1]}}, a[HALF-1:0]};
                    fsz = SZ_L;
                end
                default: begin
                    res = {{(DATA_W-8){a[7]}}, a[7:0]};
                    fsz = SZ_L;
                end
            endcase
        end
        // R9
        ext_fill_chk: assert (op != OP_EXT || size == SZ_B
                              || res[DATA_W-1:HALF] == '0 || res[DATA_W-1:HALF] == '1)
            else $error("extension upper half not uniform");
        // R10
        swap_bits_kept_chk: assert (op != OP_SWAP || $countones(res) == $countones(a))
            else $error("swap lost bits");
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
(
    input  logic [31:0] opnd_i,
    input  logic [1:0]  size_i,
    input  logic [3:0]  op_i,
    input  logic        cnt_src_i,
    input  logic [2:0]  imm_cnt_i,
    input  logic [5:0]  reg_cnt_i,
    input  logic        mem_i,
    input  logic        x_i,
    output logic [31:0] result_o,
    output logic        x_o,
    output logic        n_o,
    output logic        z_o,
    output logic        v_o,
    output logic        c_o
);
    op_e               op;
    size_e             esz, xfsz, fsz;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh_res, ro_res, xs_res;
    logic              sh_c, sh_v, sh_x, ro_c, ro_x;
    flags_t            fl;

    assign op  = op_e'(op_i);
    assign esz = mem_i ? SZ_W : size_e'(size_i);

    shrot_cnt u_cnt (
        .src_reg  (cnt_src_i),
        .imm_code (imm_cnt_i),
        .reg_val  (reg_cnt_i),
        .mem_op   (mem_i),
        .cnt      (cnt)
    );

    shrot_shift u_shift (
        .op    (op),
        .size  (esz),
        .a     (opnd_i),
        .cnt   (cnt),
        .x_in  (x_i),
        .res   (sh_res),
        .c     (sh_c),
        .v     (sh_v),
        .x_out (sh_x)
    );

    shrot_rot u_rot (
        .op    (op),
        .size  (esz),
        .a     (opnd_i),
        .cnt   (cnt),
        .x_in  (x_i),
        .res   (ro_res),
        .c     (ro_c),
        .x_out (ro_x)
    );

    shrot_xsw u_xsw (
        .op   (op),
        .size (esz),
        .a    (opnd_i),
        .res  (xs_res),
        .fsz  (xfsz)
    );

    always_comb begin
        fl       = '0;
        fl.x     = x_i;
        fsz      = esz;
        result_o = opnd_i;
        case (op)
            OP_ASL, OP_ASR, OP_LSL, OP_LSR: begin
                result_o = sh_res;
                fl.c     = sh_c;
                fl.v     = (op == OP_ASL) ? sh_v : 1'b0;
                fl.x     = sh_x;
            end
            OP_ROL, OP_ROR, OP_ROXL, OP_ROXR: begin
                result_o = ro_res;
                fl.c     = ro_c;
                fl.x     = ro_x;
            end
            OP_EXT, OP_SWAP: begin
                result_o = xs_res;
                fsz      = xfsz;
            end
            default: ;
        endcase
        fl.n = sz_msb(result_o, fsz);
        fl.z = ((result_o & sz_mask(fsz)) == '0);
        x_o  = fl.x;
        n_o  = fl.n;
        z_o  = fl.z;
        v_o  = fl.v;
        c_o  = fl.c;

        // R11
        v_only_asl_chk: assert (op == OP_ASL || !v_o)
            else $error("overflow raised outside ASL");
        // R3
        mem_one_bit_chk: assert (!mem_i || cnt == 6'd1)
            else $error("memory operand count not one");
    end
endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
    logic        clk = 1'b0;
    logic [31:0] opnd_i = '0;
    logic [1:0]  size_i = '0;
    logic [3:0]  op_i = '0;
    logic        cnt_src_i = 1'b0;
    logic [2:0]  imm_cnt_i = '0;
    logic [5:0]  reg_cnt_i = '0;
    logic        mem_i = 1'b0;
    logic        x_i = 1'b0;
    logic [31:0] result_o;
    logic        x_o, n_o, z_o, v_o, c_o;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    shrot_unit u_dut (
        .opnd_i(opnd_i), .size_i(size_i), .op_i(op_i), .cnt_src_i(cnt_src_i),
        .imm_cnt_i(imm_cnt_i), .reg_cnt_i(reg_cnt_i), .mem_i(mem_i), .x_i(x_i),
        .result_o(result_o), .x_o(x_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
    );

    function automatic logic [31:0] msk_of(int w);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    endfunction

    // step-by-step model built from the requirements
    function automatic void model(input logic [3:0] op, input logic [1:0] sz, input logic [31:0] a,
                                  input logic xin, input int n,
                                  output logic [31:0] r, output logic [4:0] f);
        int w, fw;
        logic [31:0] m, v;
        logic x, c, ov, msb, nm;
        w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        fw = w;
        m  = msk_of(w);
        v  = a & m;
        x  = xin;
        c  = 1'b0;
        ov = 1'b0;
        r  = a;
        if (op <= 4'd7) begin
            for (int k = 0; k < n; k++) begin
                msb = v[w-1];
                case (op)
                    4'd0, 4'd2: begin c = msb; v = (v << 1) & m; if (v[w-1] != msb) ov = 1'b1; end
                    4'd1: begin c = v[0]; v = (v >> 1) | (32'(msb) << (w-1)); end
                    4'd3: begin c = v[0]; v = v >> 1; end
                    4'd4: begin c = msb; v = ((v << 1) & m) | 32'(c); end
                    4'd5: begin c = v[0]; v = (v >> 1) | (32'(c) << (w-1)); end
                    4'd6: begin c = msb; v = ((v << 1) & m) | 32'(x); x = c; end
                    default: begin c = v[0]; v = (v >> 1) | (32'(x) << (w-1)); x = c; end
                endcase
            end
            if (op != 4'd0) ov = 1'b0;
            if (n == 0) c = (op >= 4'd6) ? xin : 1'b0;
            else if (op <= 4'd3) x = c;
            r = (a & ~m) | v;
        end else if (op == 4'd8) begin
            case (sz)
                2'd0:    begin r = {a[31:16], {8{a[7]}}, a[7:0]}; fw = 16; end
                2'd1:    begin r = {{16{a[15]}}, a[15:0]}; fw = 32; end
                default: begin r = {{24{a[7]}}, a[7:0]}; fw = 32; end
            endcase
        end else begin
            r  = {a[15:0], a[31:16]};
            fw = 32;
        end
        nm = r[fw-1];
        f  = {x, nm, ((r & msk_of(fw)) == 32'd0), ov, c};
    endfunction

    task automatic apply(input logic [3:0] op, input logic [1:0] sz, input logic [31:0] a,
                         input logic xin, input logic src, input logic [2:0] imm,
                         input logic [5:0] rc, input logic mem, input string tag_in);
        logic [31:0] er;
        logic [4:0]  ef, af;
        int          n;
        logic [1:0]  esz;
        string       tag;
        @(negedge clk);
        opnd_i = a; size_i = sz; op_i = op; x_i = xin;
        cnt_src_i = src; imm_cnt_i = imm; reg_cnt_i = rc; mem_i = mem;
        #1;
        n   = mem ? 1 : (!src ? ((imm == 3'd0) ? 8 : int'(imm)) : int'(rc));
        esz = mem ? 2'd1 : sz;
        model(op, esz, a, xin, n, er, ef);
        tag = tag_in;
        if (tag == "") begin
            case (op)
                4'd0: tag = "R5";
                4'd1, 4'd2, 4'd3: tag = "R4";
                4'd4, 4'd5: tag = "R6";
                4'd6, 4'd7: tag = "R7";
                4'd8: tag = "R9";
                default: tag = "R10";
            endcase
            if (op <= 4'd7 && n == 0) tag = "R8";
        end
        af = {x_o, n_o, z_o, v_o, c_o};
        vecs++;
        if (result_o !== er || af[4] !== ef[4] || af[1:0] !== ef[1:0]) begin
            errs++;
            $display("FAIL %s op=%0d sz=%0d a=%h n=%0d: result %h flags(xnzvc) %b, expected %h %b",
                     tag, op, esz, a, n, result_o, af, er, ef);
        end else if (af[3:2] !== ef[3:2]) begin
            errs++;
            $display("FAIL R11 op=%0d sz=%0d a=%h n=%0d: N/Z %b, expected %b",
                     op, esz, a, n, af[3:2], ef[3:2]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not finish, actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240);
        repeat (3) @(posedge clk);
        // reset-state style check: all-zero inputs, ASL byte with immediate 8
        apply(4'd0, 2'd0, 32'h0, 1'b0, 1'b0, 3'd0, 6'd0, 1'b0, "R1");
        // R1 immediate code 0 means 8, code 3 means 3
        apply(4'd2, 2'd1, 32'h0000_1234, 1'b0, 1'b0, 3'd0, 6'd0, 1'b0, "R1");
        apply(4'd3, 2'd2, 32'h8000_00F0, 1'b1, 1'b0, 3'd3, 6'd0, 1'b0, "R1");
        // R2 register counts beyond the width
        apply(4'd3, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b1, 3'd0, 6'd63, 1'b0, "R2");
        apply(4'd1, 2'd0, 32'h0000_0080, 1'b0, 1'b1, 3'd0, 6'd40, 1'b0, "R2");
        apply(4'd2, 2'd1, 32'h0000_8001, 1'b0, 1'b1, 3'd0, 6'd16, 1'b0, "R2");
        // R3 memory operand: one bit at word size despite byte size and count 7
        apply(4'd2, 2'd0, 32'hAAAA_C001, 1'b0, 1'b1, 3'd7, 6'd7, 1'b1, "R3");
        apply(4'd7, 2'd2, 32'h1234_0001, 1'b1, 1'b0, 3'd5, 6'd0, 1'b1, "R3");
        // R5 sign change detection
        apply(4'd0, 2'd0, 32'h0000_0040, 1'b0, 1'b0, 3'd1, 6'd0, 1'b0, "R5");
        apply(4'd0, 2'd0, 32'h0000_00C0, 1'b0, 1'b0, 3'd1, 6'd0, 1'b0, "R5");
        apply(4'd0, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b1, 3'd0, 6'd33, 1'b0, "R5");
        // R6 full cycles of plain rotates
        apply(4'd4, 2'd0, 32'h0000_0081, 1'b1, 1'b1, 3'd0, 6'd8, 1'b0, "R6");
        apply(4'd5, 2'd2, 32'h8000_0001, 1'b0, 1'b1, 3'd0, 6'd33, 1'b0, "R6");
        // R7 extend rotates around 9, 17 and 33 bits
        apply(4'd6, 2'd0, 32'h0000_0055, 1'b1, 1'b1, 3'd0, 6'd9, 1'b0, "R7");
        apply(4'd7, 2'd1, 32'h0000_8000, 1'b0, 1'b1, 3'd0, 6'd17, 1'b0, "R7");
        apply(4'd6, 2'd2, 32'h8000_0000, 1'b0, 1'b1, 3'd0, 6'd34, 1'b0, "R7");
        // R8 zero count for every shift and rotate
        for (int o = 0; o < 8; o++)
            apply(4'(o), 2'd1, 32'hDEAD_BEEF, 1'b1, 1'b1, 3'd0, 6'd0, 1'b0, "R8");
        // R9 / R10 directed
        apply(4'd8, 2'd0, 32'h1234_0080, 1'b1, 1'b0, 3'd1, 6'd0, 1'b0, "R9");
        apply(4'd8, 2'd1, 32'h0000_8000, 1'b0, 1'b0, 3'd1, 6'd0, 1'b0, "R9");
        apply(4'd8, 2'd2, 32'hFFFF_FF00, 1'b0, 1'b0, 3'd1, 6'd0, 1'b0, "R9");
        apply(4'd9, 2'd2, 32'h0000_8001, 1'b1, 1'b0, 3'd1, 6'd0, 1'b0, "R10");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] rop;
            rop = 4'($urandom_range(0, 9));
            apply(rop, 2'($urandom_range(0, 2)), $urandom(), 1'($urandom()),
                  1'($urandom()), 3'($urandom()), 6'($urandom()),
                  ($urandom_range(0, 15) == 0), "");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule